// File: doc/BRIEF.md
# Pin-Mapped Serial Peripheral Master

This block is a serial peripheral interface master that talks to up to four external
peripherals over a shared set of 24 general-purpose pins. Each peripheral owns a small
pin map of four indices: the pin carrying the serial clock, the pin it reads serial data
from, the pin it writes serial data to, and its active-low select. Any of the four roles
may sit on any pin, and the maps can be rewritten at run time between transfers.

A transfer is launched by a one-cycle request carrying the peripheral number, a clock
divider, a choice of sampling edge, a write word and a bit count of 1 to 32. The engine
selects the peripheral, clocks the low bits of the write word out most significant bit
first, shifts in the same number of bits from the mapped input pin, and releases the
select. The resulting pin levels go to the pin-source multiplexer of the chip. The
direction of the pads is set up elsewhere.

Top module: `spi_pinmap_master`

## Requirements
- R1: Each peripheral d holds four pin indices (clock, input, output, select); after reset peripheral d uses pins 4d, 4d+1, 4d+2 and 4d+3 for those roles. Bit p of `pin_out` and `gpio_in` is pin index p (0 to 11 on the first bank, 12 to 23 on the second). A `cfg_we` write replaces the map of peripheral `cfg_dev` from the next cycle when no transfer is running, and is ignored while `busy` is high. An index of 24 or more connects the role to no pin, and an unconnected input reads 0.
- R2: With divider D the serial clock period is D+1 core cycles: it is high for floor((D+1)/2) cycles and low for the rest, and the first edge of a transfer is rising.
- R3: The select pin of the active peripheral goes low in the cycle after the request is taken, stays low for one low phase before the first rising edge, and returns high one low phase after the last falling edge.
- R4: The output pin carries bit len-1 of the write word first and then each lower bit, changing together with the select fall and with each falling clock edge; it returns to 0 after the last falling edge.
- R5: With `req_fall` = 0 the input pin is captured at each rising clock edge, with `req_fall` = 1 at each falling edge. `rdata` is cleared when a transfer is taken, shifts each captured bit in at bit 0, so that after the transfer its low len bits hold the captured bits with the first one most significant, and it holds its value until the next transfer is taken.
- R6: `busy` is high from the cycle after the request is taken until the cycle in which the select returns high; `done` is high for exactly that one cycle.
- R7: With no transfer running every mapped select pin is high, the clock and output roles drive 0, and pins with no role read 0.
- R8: A request with peripheral number 4 or more, a bit count of 0 or above 32, or a divider of 0 starts nothing and raises `err` for one cycle.
- R9: A request made while `busy` is high is ignored: it neither raises `err` nor changes the running transfer.
- R10: During a transfer only the active peripheral's select is low; the other peripherals' selects stay high and their clock and output roles drive 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write the pin map of one peripheral |
| cfg_dev | input | 2 | Peripheral whose map is written |
| cfg_sclk_pin | input | 5 | Pin index for the serial clock |
| cfg_sdi_pin | input | 5 | Pin index the peripheral's read data comes from |
| cfg_sdo_pin | input | 5 | Pin index the write data goes to |
| cfg_cs_pin | input | 5 | Pin index for the active-low select |
| req_valid | input | 1 | One-cycle transfer request |
| req_dev | input | 3 | Peripheral number of the request |
| req_div | input | 8 | Clock divider D, period D+1 cycles |
| req_fall | input | 1 | 1 = capture input on falling edge, 0 = rising |
| req_wdata | input | 32 | Write word, low len bits sent |
| req_len | input | 6 | Bit count, 1 to 32 |
| gpio_in | input | 24 | Levels seen on the pins |
| pin_out | output | 24 | Levels this engine wants on the pins |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle rejected-request pulse |
| rdata | output | 32 | Captured read data |

## Verification
The assertions assume that the clock role of a running transfer is never shared with a select or output pin, and that `req_valid` and `cfg_we` are single-cycle strobes sampled only at clock edges. The bench keeps every pin map free of overlapping roles, including the remapped ones, drives all inputs half a cycle away from the rising edge, and randomises only the `gpio_in` levels every cycle so that captured data never depends on stimulus timing. Rejected and ignored requests are issued both while idle and in the middle of a transfer, and a map write is attempted during a transfer and then exercised afterwards.

// File: rtl/spm_pkg.sv
// Shared constants and types of the pin-mapped serial master.
// Assumes two banks of twelve pins; pin index p is bit p of the pin vectors.
package spm_pkg;
    localparam int BANK_PINS = 12;
    localparam int NUM_BANKS = 2;
    localparam int NUM_PINS  = BANK_PINS * NUM_BANKS;
    localparam int PIN_W     = $clog2(NUM_PINS + 1);

    // Pin indices of the four roles of one peripheral.
    typedef struct packed {
        logic [PIN_W-1:0] sclk;
        logic [PIN_W-1:0] sdi;
        logic [PIN_W-1:0] sdo;
        logic [PIN_W-1:0] cs;
    } pin_map_t;
endpackage

// File: rtl/spm_pinmap.sv
// Per-peripheral pin map registers.
// Assumes the caller blocks writes while a transfer runs (lock input).
module spm_pinmap
    import spm_pkg::*;
#(
    parameter int NUM_DEV = 4,
    localparam int DEV_W  = $clog2(NUM_DEV)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DEV_W-1:0]        wr_dev,
    input  pin_map_t                wr_map,
    input  logic                    lock,
    output pin_map_t [NUM_DEV-1:0]  maps
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        // Hold or update the map of peripheral d.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                maps[d].sclk <= PIN_W'(4 * d);
                maps[d].sdi  <= PIN_W'(4 * d + 1);
                maps[d].sdo  <= PIN_W'(4 * d + 2);
                maps[d].cs   <= PIN_W'(4 * d + 3);
            end else if (wr_en && !lock && (wr_dev == DEV_W'(d))) begin
                maps[d] <= wr_map;
            end
        end
    end
endmodule

// File: rtl/spm_shift_engine.sv
// Clock generator and shifter of one serial transfer.
// Assumes start arrives only for a validated request while idle: div >= 1,
// 1 <= len <= MAX_BITS.
module spm_shift_engine #(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DIV_W-1:0]    div,
    input  logic                fall,
    input  logic [MAX_BITS-1:0] wdata,
    input  logic [LEN_W-1:0]    len,
    input  logic                sdi,
    output logic                active,
    output logic                done,
    output logic                sclk,
    output logic                sdo,
    output logic [MAX_BITS-1:0] rdata
);
    logic [DIV_W:0]       period;
    logic [DIV_W:0]       hi_len;
    logic [DIV_W:0]       lo_len;
    logic [MAX_BITS-1:0]  aligned;
    logic [DIV_W-1:0]     cnt;
    logic [DIV_W-1:0]     hi_m1;
    logic [DIV_W-1:0]     lo_m1;
    logic [LEN_W-1:0]     bits_left;
    logic [MAX_BITS-1:0]  shreg;
    logic                 fall_q;

    // Phase lengths and left-aligned write word of a new request.
    always_comb begin
        period  = {1'b0, div} + 1'b1;
        hi_len  = period >> 1;
        lo_len  = period - hi_len;
        aligned = wdata << (LEN_W'(MAX_BITS) - len);
    end

    // Phase counter, clock level, shift and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            done      <= 1'b0;
            sclk      <= 1'b0;
            sdo       <= 1'b0;
            rdata     <= '0;
            cnt       <= '0;
            hi_m1     <= '0;
            lo_m1     <= '0;
            bits_left <= '0;
            shreg     <= '0;
            fall_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active    <= 1'b1;
                    sclk      <= 1'b0;
                    hi_m1     <= DIV_W'(hi_len - 1'b1);
                    lo_m1     <= DIV_W'(lo_len - 1'b1);
                    cnt       <= DIV_W'(lo_len - 1'b1);
                    bits_left <= len;
                    shreg     <= aligned;
                    sdo       <= aligned[MAX_BITS-1];
                    rdata     <= '0;
                    fall_q    <= fall;
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (!sclk) begin
                if (bits_left == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    sclk <= 1'b1;
                    cnt  <= hi_m1;
                    if (!fall_q) rdata <= {rdata[MAX_BITS-2:0], sdi};
                end
            end else begin
                sclk      <= 1'b0;
                cnt       <= lo_m1;
                bits_left <= bits_left - 1'b1;
                shreg     <= shreg << 1;
                sdo       <= (bits_left == LEN_W'(1)) ? 1'b0 : shreg[MAX_BITS-2];
                if (fall_q) rdata <= {rdata[MAX_BITS-2:0], sdi};
            end
        end
    end
endmodule

// File: rtl/spm_pin_router.sv
// Places the clock, output and select levels onto pin indices and picks
// the input pin of the active peripheral.
// Assumes roles of one transfer do not share a pin; shared pins OR together.
module spm_pin_router
    import spm_pkg::*;
#(
    parameter int NUM_DEV = 4,
    localparam int DEV_W  = $clog2(NUM_DEV)
) (
    input  pin_map_t [NUM_DEV-1:0]  maps,
    input  logic                    active,
    input  logic [DEV_W-1:0]        act_dev,
    input  logic                    sclk,
    input  logic                    sdo,
    input  logic [NUM_PINS-1:0]     gpio_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic                    sdi
);
    pin_map_t cur;

    // Build the pin vector from all selects and the active clock and output.
    always_comb begin
        cur     = maps[act_dev];
        pin_out = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if ((int'(maps[d].cs) < NUM_PINS) && !(active && (act_dev == DEV_W'(d))))
                pin_out[maps[d].cs] = 1'b1;
        end
        if (active && (int'(cur.sclk) < NUM_PINS))
            pin_out[cur.sclk] = pin_out[cur.sclk] | sclk;
        if (active && (int'(cur.sdo) < NUM_PINS))
            pin_out[cur.sdo] = pin_out[cur.sdo] | sdo;
    end

    // Read the input pin of the active peripheral, 0 when unconnected.
    always_comb begin
        sdi = 1'b0;
        if (int'(cur.sdi) < NUM_PINS) sdi = gpio_in[cur.sdi];
    end
endmodule

// File: rtl/spi_pinmap_master.sv
// Top of the pin-mapped serial master: request check, peripheral latch,
// pin maps, shift engine and pin router.
// Assumes req_valid and cfg_we are single-cycle strobes.
module spi_pinmap_master
    import spm_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 32,
    localparam int DEV_W   = $clog2(NUM_DEV),
    localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [DEV_W-1:0]    cfg_dev,
    input  logic [PIN_W-1:0]    cfg_sclk_pin,
    input  logic [PIN_W-1:0]    cfg_sdi_pin,
    input  logic [PIN_W-1:0]    cfg_sdo_pin,
    input  logic [PIN_W-1:0]    cfg_cs_pin,
    input  logic                req_valid,
    input  logic [DEV_W:0]      req_dev,
    input  logic [DIV_W-1:0]    req_div,
    input  logic                req_fall,
    input  logic [MAX_BITS-1:0] req_wdata,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [MAX_BITS-1:0] rdata
);
    pin_map_t [NUM_DEV-1:0] maps;
    pin_map_t               wr_map;
    logic                   req_bad;
    logic                   start;
    logic [DEV_W-1:0]       act_dev;
    logic                   sclk_lvl;
    logic                   sdo_lvl;
    logic                   sdi_lvl;

    // Classify a request taken while idle.
    always_comb begin
        req_bad = (int'(req_dev) >= NUM_DEV) || (req_len == '0) ||
                  (int'(req_len) > MAX_BITS) || (req_div == '0);
        start   = req_valid && !busy && !req_bad;
        wr_map  = '{sclk: cfg_sclk_pin, sdi: cfg_sdi_pin, sdo: cfg_sdo_pin, cs: cfg_cs_pin};
    end

    // Error pulse and latch of the active peripheral number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err     <= 1'b0;
            act_dev <= '0;
        end else begin
            err <= req_valid && !busy && req_bad;
            if (start) act_dev <= DEV_W'(req_dev);
        end
    end

    spm_pinmap #(.NUM_DEV(NUM_DEV)) map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_dev (cfg_dev),
        .wr_map (wr_map),
        .lock   (busy),
        .maps   (maps)
    );

    spm_shift_engine #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS)) eng_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .div    (req_div),
        .fall   (req_fall),
        .wdata  (req_wdata),
        .len    (req_len),
        .sdi    (sdi_lvl),
        .active (busy),
        .done   (done),
        .sclk   (sclk_lvl),
        .sdo    (sdo_lvl),
        .rdata  (rdata)
    );

    spm_pin_router #(.NUM_DEV(NUM_DEV)) rte_i (
        .maps    (maps),
        .active  (busy),
        .act_dev (act_dev),
        .sclk    (sclk_lvl),
        .sdo     (sdo_lvl),
        .gpio_in (gpio_in),
        .pin_out (pin_out),
        .sdi     (sdi_lvl)
    );
endmodule

// File: rtl/spm_checker.sv
// Temporal checks of the pin-mapped serial master, bound to its top.
// Assumes req_valid is sampled only at clock edges.
module spm_checker #(
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             sclk_lvl,
    input logic             sdo_lvl
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R6
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && done)); // R8
    AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_len == '0)) |=> (err && !busy)); // R8
    AST_BUSY_REQ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !err); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_lvl && !sdo_lvl)); // R7
endmodule

bind spi_pinmap_master spm_checker #(.LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .req_valid (req_valid),
    .req_len   (req_len),
    .sclk_lvl  (sclk_lvl),
    .sdo_lvl   (sdo_lvl)
);

// File: tb/spi_pinmap_master_tb_top.sv
// Bench: behavioural per-cycle model of the serial master, compared every cycle.
module spi_pinmap_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_dev = '0;
    logic [4:0]  cfg_sclk_pin = '0, cfg_sdi_pin = '0, cfg_sdo_pin = '0, cfg_cs_pin = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_dev = '0;
    logic [7:0]  req_div = '0;
    logic        req_fall = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [5:0]  req_len = '0;
    logic [23:0] gpio_in = '0;
    logic [23:0] pin_out;
    logic        busy, done, err;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;

    // model state
    int  m_sclk[4], m_sdi[4], m_sdo[4], m_cs[4];
    bit  m_busy = 0, m_done = 0, m_err = 0, m_fall = 0;
    int  m_dev = 0, m_n = 0, m_len = 0, m_p = 2, m_l = 1;
    logic [31:0] m_w = '0, m_rd = '0;
    int  done_seen = 0, err_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pinmap_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_sclk_pin(cfg_sclk_pin), .cfg_sdi_pin(cfg_sdi_pin),
        .cfg_sdo_pin(cfg_sdo_pin), .cfg_cs_pin(cfg_cs_pin),
        .req_valid(req_valid), .req_dev(req_dev), .req_div(req_div),
        .req_fall(req_fall), .req_wdata(req_wdata), .req_len(req_len),
        .gpio_in(gpio_in), .pin_out(pin_out), .busy(busy), .done(done),
        .err(err), .rdata(rdata)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < 4; d++) begin
            m_sclk[d] = 4*d; m_sdi[d] = 4*d+1; m_sdo[d] = 4*d+2; m_cs[d] = 4*d+3;
        end
        m_busy = 0; m_done = 0; m_err = 0; m_rd = '0;
    endtask

    // Advance the model over one rising edge using the inputs held at it.
    task automatic model_edge();
        bit was_busy = m_busy;
        m_done = 0; m_err = 0;
        if (was_busy) begin
            int nn = m_n + 1;
            bit b = (m_sdi[m_dev] < NP) ? gpio_in[m_sdi[m_dev]] : 1'b0;
            if (!m_fall && nn < m_len*m_p && (nn % m_p) == m_l) m_rd = {m_rd[30:0], b};
            if (m_fall && nn > 0 && nn <= m_len*m_p && (nn % m_p) == 0) m_rd = {m_rd[30:0], b};
            if (nn == m_len*m_p + m_l) begin m_busy = 0; m_done = 1; end
            else m_n = nn;
        end else begin
            if (cfg_we) begin
                m_sclk[cfg_dev] = cfg_sclk_pin; m_sdi[cfg_dev] = cfg_sdi_pin;
                m_sdo[cfg_dev] = cfg_sdo_pin;   m_cs[cfg_dev] = cfg_cs_pin;
            end
            if (req_valid) begin
                if (req_dev >= 4 || req_len == 0 || req_len > 32 || req_div == 0) m_err = 1;
                else begin
                    m_busy = 1; m_n = 0; m_rd = '0; m_dev = req_dev; m_len = req_len;
                    m_w = req_wdata; m_fall = req_fall;
                    m_p = req_div + 1; m_l = m_p - m_p/2;
                end
            end
        end
    endtask

    function automatic logic [23:0] model_pins();
        logic [23:0] e = '0;
        for (int d = 0; d < 4; d++)
            if (m_cs[d] < NP && !(m_busy && m_dev == d)) e[m_cs[d]] = 1'b1;
        if (m_busy && m_n < m_len*m_p) begin
            bit s = (m_n % m_p) >= m_l;
            bit o = m_w[m_len - 1 - m_n/m_p];
            if (m_sclk[m_dev] < NP) e[m_sclk[m_dev]] = e[m_sclk[m_dev]] | s;
            if (m_sdo[m_dev] < NP)  e[m_sdo[m_dev]]  = e[m_sdo[m_dev]] | o;
        end
        return e;
    endfunction

    // One clock: model update at the edge, compare half a cycle later, new pin levels.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(pin_out == model_pins(), "R1/R2/R3/R4/R7/R10 pin levels", 32'(pin_out), 32'(model_pins()));
        check(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
        check(done == m_done, "R6 done", 32'(done), 32'(m_done));
        check(err == m_err, "R8 err", 32'(err), 32'(m_err));
        check(rdata == m_rd, "R5 rdata", rdata, m_rd);
        if (done) done_seen++;
        if (err) err_seen++;
        gpio_in = 24'($urandom);
    endtask

    task automatic request(input int dev, input int div, input bit fe, input logic [31:0] w, input int len);
        req_valid = 1; req_dev = 3'(dev); req_div = 8'(div); req_fall = fe;
        req_wdata = w; req_len = 6'(len);
        cyc();
        req_valid = 0;
    endtask

    task automatic xfer(input int dev, input int div, input bit fe, input logic [31:0] w, input int len);
        int d0 = done_seen;
        request(dev, div, fe, w, len);
        while (m_busy) cyc();
        check(done_seen == d0 + 1, "R6 one done pulse per transfer", 32'(done_seen - d0), 32'd1);
    endtask

    task automatic map(input int dev, input int s, input int i, input int o, input int c);
        cfg_we = 1; cfg_dev = 2'(dev);
        cfg_sclk_pin = 5'(s); cfg_sdi_pin = 5'(i); cfg_sdo_pin = 5'(o); cfg_cs_pin = 5'(c);
        cyc();
        cfg_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int e0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R7: reset state, selects at 3,7,11,15 high
        check(pin_out == 24'h008888, "R7 idle pins after reset", 32'(pin_out), 32'h008888);
        check(busy == 0, "R6 idle after reset", 32'(busy), 32'd0);

        xfer(0, 3, 0, 32'hA5, 8);              // R2 R5 rising capture
        repeat (2) cyc();
        xfer(1, 4, 1, 32'h13, 5);              // R5 falling capture, odd period
        xfer(3, 1, 0, 32'h8000_0001, 1);       // shortest transfer, bit count 1
        map(2, 23, 12, 14, 16);                // R1 remap across banks
        xfer(2, 1, 1, 32'hDEAD_BEEF, 32);      // R4 full 32 bits
        xfer(2, 2, 0, 32'h1234_5678, 32);

        // R8 rejected requests while idle
        e0 = err_seen;
        request(4, 3, 0, 32'h1, 8);  cyc();
        request(0, 3, 0, 32'h1, 0);  cyc();
        request(0, 3, 0, 32'h1, 33); cyc();
        request(0, 0, 0, 32'h1, 8);  cyc();
        check(err_seen == e0 + 4, "R8 four error pulses", 32'(err_seen - e0), 32'd4);
        check(busy == 0, "R8 no transfer after rejects", 32'(busy), 32'd0);

        // R9 and R1: requests and map writes during a transfer are ignored
        e0 = err_seen;
        request(1, 5, 0, 32'h3C, 6);
        repeat (4) cyc();
        request(4, 0, 0, 32'h0, 0);
        request(0, 2, 1, 32'hFF, 4);
        map(0, 20, 21, 22, 17);
        while (m_busy) cyc();
        check(err_seen == e0, "R9 no error for request while busy", 32'(err_seen - e0), 32'd0);
        xfer(0, 2, 0, 32'h9, 4);               // old map of peripheral 0 still used

        map(3, 18, 30, 19, 20);                // R1 unconnected input reads 0
        xfer(3, 3, 0, 32'h5A, 8);
        check(rdata == 32'h0, "R1 unconnected input captures 0", rdata, 32'h0);

        // back-to-back: request held high through done
        request(1, 1, 1, 32'h2, 3);
        req_valid = 1;
        while (m_busy) cyc();
        cyc();
        req_valid = 0;
        while (m_busy) cyc();
        repeat (3) cyc();
        check(pin_out == model_pins(), "R7 idle pins at end", 32'(pin_out), 32'(model_pins()));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule